// File: doc/BRIEF.md
# Coherent Counter Capture with Speed History

This block sits beside the position counters of an incremental encoder interface. It owns two counters of its own. The first is a speed counter that measures the number of clock cycles since the last count step. The second is a free-running timer. It also holds three shadow banks: a read bank and two snapshot banks. Each bank stores four words: phase, revolution, speed and timer. All four words of a bank are sampled on one clock edge, so software always sees a matching set.

The read bank loads on two kinds of request. One is a single-cycle software strobe. The other is any event flag whose matching enable bit is set. The snapshot banks load on rising edges of an external snapshot input while snapshot capture is enabled. Successive edges fill bank 0 and bank 1 in turn.

A four-deep history of the speed count is also kept. Each time the A/B levels leave the state where both are low, the history shifts and takes in the current speed count.

Top module: `qcap_unit`

## Requirements
- R1: While reset is held and on its release, the speed count, timer, all twelve bank words and all four history entries are 0. The snapshot selector points at bank 0.
- R2: The timer increments by one every clock cycle and wraps from its maximum value to 0.
- R3: In the cycle after `step` is high, the speed count is 0. Otherwise it grows by one per cycle and stays at 2^SPD_W-1 once it gets there.
- R4: A high `sw_read` at a clock edge loads the read bank with the four words formed from the values present just before that edge. With no load request, the read bank holds its contents.
- R5: Each bit i of `evt_flag` loads the read bank only when bit i of `evt_en` is also 1. A flag with its enable bit at 0 leaves the read bank unchanged.
- R6: A rising edge of `snap_in`, seen while `snap_en` is 1, loads a snapshot bank. The first such edge after reset loads bank 0, the next loads bank 1, and so on alternately. Edges while `snap_en` is 0 load nothing and do not advance the alternation.
- R7: The phase word has the phase count in bits 20:0, direction in bit 30, the A level in bit 26 and the B level in bit 25. All other bits are 0.
- R8: The speed word has the speed count zero-extended from bit 0, direction in bit 31, the A level in bit 30 and the B level in bit 29. The revolution word is the `rev_cnt` input unchanged. The timer word is the timer zero-extended.
- R9: When the registered A/B pair was 00 and the present pair is not 00, the history shifts by one entry at that edge. Entry 0 takes the zero-extended speed count and entry k takes the old entry k-1. Otherwise all entries hold. The registered pair resets to 11, so the first cycle after reset never counts as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Count-step strobe from the quadrature decoder |
| dir | input | 1 | Rotation direction, 1 = reverse |
| ab_a | input | 1 | Level of the A input |
| ab_b | input | 1 | Level of the B input |
| ph_cnt | input | PH_W | Live phase count |
| rev_cnt | input | 32 | Live revolution count |
| sw_read | input | 1 | Software read strobe, one cycle |
| evt_flag | input | 4 | Event flag set pulses |
| evt_en | input | 4 | Per-flag read-bank load enables |
| snap_in | input | 1 | External snapshot request |
| snap_en | input | 1 | Snapshot capture enable |
| spd_cnt | output | SPD_W | Live speed count |
| tmr_cnt | output | TMR_W | Live timer |
| rd_ph | output | 32 | Read bank phase word |
| rd_rev | output | 32 | Read bank revolution word |
| rd_spd | output | 32 | Read bank speed word |
| rd_tmr | output | 32 | Read bank timer word |
| s0_ph | output | 32 | Snapshot bank 0 phase word |
| s0_rev | output | 32 | Snapshot bank 0 revolution word |
| s0_spd | output | 32 | Snapshot bank 0 speed word |
| s0_tmr | output | 32 | Snapshot bank 0 timer word |
| s1_ph | output | 32 | Snapshot bank 1 phase word |
| s1_rev | output | 32 | Snapshot bank 1 revolution word |
| s1_spd | output | 32 | Snapshot bank 1 speed word |
| s1_tmr | output | 32 | Snapshot bank 1 timer word |
| hist0 | output | 32 | Newest speed history entry |
| hist1 | output | 32 | Speed history entry 1 |
| hist2 | output | 32 | Speed history entry 2 |
| hist3 | output | 32 | Oldest speed history entry |

## Verification
The random run mixes sparse and dense count steps with A/B levels that walk through every pair. This separates history shifts that come from a real exit out of 00 from shifts on any change of level. Event flags arrive both with and without their enable bits, which tells a masked flag apart from an enabled one. The snapshot input toggles while its enable changes, so alternation that advances on gated-off edges is caught. Directed cases fix the field positions in the phase and speed words and hold off steps long enough to reach saturation of a narrowed speed counter.

// File: rtl/qcap_pkg.sv
package qcap_pkg;
  localparam int WORD_W = 32;
  localparam int N_EVT  = 4;
  localparam int N_HIST = 4;
  localparam int N_BANK = 3;

  // Bank slots: read bank, then the two snapshot banks.
  localparam int SLOT_RD = 0;
  localparam int SLOT_S0 = 1;
  localparam int SLOT_S1 = 2;

  // Field positions inside the packed words.
  localparam int PH_DIR_BIT  = 30;
  localparam int PH_A_BIT    = 26;
  localparam int PH_B_BIT    = 25;
  localparam int SPD_DIR_BIT = 31;
  localparam int SPD_A_BIT   = 30;
  localparam int SPD_B_BIT   = 29;

  typedef struct packed {
    logic [WORD_W-1:0] ph;
    logic [WORD_W-1:0] rev;
    logic [WORD_W-1:0] spd;
    logic [WORD_W-1:0] tmr;
  } qcap_bank_t;
endpackage

// File: rtl/qcap_counters.sv
module qcap_counters #(
  parameter int SPD_W = 28,
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SPD_W-1:0] spd_o,
  output logic [TMR_W-1:0] tmr_o
);
  localparam logic [SPD_W-1:0] SPD_MAX = {SPD_W{1'b1}};

  logic [SPD_W-1:0] spd_q, spd_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    if (step)                spd_d = '0;
    else if (spd_q == SPD_MAX) spd_d = spd_q;
    else                     spd_d = spd_q + 1'b1;
    tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= '0;
      tmr_q <= '0;
    end else begin
      spd_q <= spd_d;
      tmr_q <= tmr_d;
    end
  end

  assign spd_o = spd_q;
  assign tmr_o = tmr_q;
endmodule

// File: rtl/qcap_bank.sv
module qcap_bank
  import qcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  qcap_bank_t din,
  output qcap_bank_t q
);
  qcap_bank_t bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load) bank_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign q = bank_q;
endmodule

// File: rtl/qcap_history.sv
module qcap_history
  import qcap_pkg::*;
#(
  parameter int DEPTH = N_HIST
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ab_a,
  input  logic                         ab_b,
  input  logic [WORD_W-1:0]            din,
  output logic [DEPTH-1:0][WORD_W-1:0] hist_o
);
  logic [1:0]                   ab_prev_q;
  logic                         shift_en;
  logic [DEPTH-1:0][WORD_W-1:0] hist_q, hist_d;

  assign shift_en = (ab_prev_q == 2'b00) && ({ab_a, ab_b} != 2'b00);

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d[0] = din;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q[k] <= '0;
      else if (shift_en) hist_q[k] <= hist_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q[0] <= '0;
      ab_prev_q <= 2'b11;
    end else begin
      hist_q[0] <= hist_d[0];
      ab_prev_q <= {ab_a, ab_b};
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/qcap_unit.sv
module qcap_unit
  import qcap_pkg::*;
#(
  parameter int PH_W  = 21,
  parameter int SPD_W = 28,
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             dir,
  input  logic             ab_a,
  input  logic             ab_b,
  input  logic [PH_W-1:0]  ph_cnt,
  input  logic [31:0]      rev_cnt,
  input  logic             sw_read,
  input  logic [3:0]       evt_flag,
  input  logic [3:0]       evt_en,
  input  logic             snap_in,
  input  logic             snap_en,
  output logic [SPD_W-1:0] spd_cnt,
  output logic [TMR_W-1:0] tmr_cnt,
  output logic [31:0]      rd_ph,
  output logic [31:0]      rd_rev,
  output logic [31:0]      rd_spd,
  output logic [31:0]      rd_tmr,
  output logic [31:0]      s0_ph,
  output logic [31:0]      s0_rev,
  output logic [31:0]      s0_spd,
  output logic [31:0]      s0_tmr,
  output logic [31:0]      s1_ph,
  output logic [31:0]      s1_rev,
  output logic [31:0]      s1_spd,
  output logic [31:0]      s1_tmr,
  output logic [31:0]      hist0,
  output logic [31:0]      hist1,
  output logic [31:0]      hist2,
  output logic [31:0]      hist3
);
  logic [SPD_W-1:0] spd_live;
  logic [TMR_W-1:0] tmr_live;

  qcap_counters #(.SPD_W(SPD_W), .TMR_W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .spd_o(spd_live), .tmr_o(tmr_live)
  );

  // Word packing shared by every bank and the history.
  qcap_bank_t        cur;
  logic [WORD_W-1:0] spd_plain;

  always_comb begin
    spd_plain              = '0;
    spd_plain[SPD_W-1:0]   = spd_live;
    cur                    = '0;
    cur.ph[PH_W-1:0]       = ph_cnt;
    cur.ph[PH_DIR_BIT]     = dir;
    cur.ph[PH_A_BIT]       = ab_a;
    cur.ph[PH_B_BIT]       = ab_b;
    cur.rev                = rev_cnt;
    cur.spd                = spd_plain;
    cur.spd[SPD_DIR_BIT]   = dir;
    cur.spd[SPD_A_BIT]     = ab_a;
    cur.spd[SPD_B_BIT]     = ab_b;
    cur.tmr[TMR_W-1:0]     = tmr_live;
  end

  // Snapshot edge detection and bank alternation.
  logic snap_prev_q, snap_prev_d;
  logic snap_sel_q,  snap_sel_d;
  logic snap_fire;

  assign snap_fire = snap_en && snap_in && !snap_prev_q;

  always_comb begin
    snap_prev_d = snap_in;
    snap_sel_d  = snap_sel_q;
    if (snap_fire) snap_sel_d = ~snap_sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_prev_q <= 1'b0;
      snap_sel_q  <= 1'b0;
    end else begin
      snap_prev_q <= snap_prev_d;
      snap_sel_q  <= snap_sel_d;
    end
  end

  // Load requests per bank slot.
  logic [N_BANK-1:0] bank_ld;
  always_comb begin
    bank_ld          = '0;
    bank_ld[SLOT_RD] = sw_read || (|(evt_flag & evt_en));
    bank_ld[SLOT_S0] = snap_fire && !snap_sel_q;
    bank_ld[SLOT_S1] = snap_fire &&  snap_sel_q;
  end

  qcap_bank_t bank_q [N_BANK];

  for (genvar i = 0; i < N_BANK; i++) begin : g_bank
    qcap_bank u_bank (
      .clk(clk), .rst_n(rst_n), .load(bank_ld[i]), .din(cur), .q(bank_q[i])
    );
  end

  logic [N_HIST-1:0][WORD_W-1:0] hist_w;

  qcap_history #(.DEPTH(N_HIST)) u_hist (
    .clk(clk), .rst_n(rst_n), .ab_a(ab_a), .ab_b(ab_b),
    .din(spd_plain), .hist_o(hist_w)
  );

  assign spd_cnt = spd_live;
  assign tmr_cnt = tmr_live;
  assign rd_ph   = bank_q[SLOT_RD].ph;
  assign rd_rev  = bank_q[SLOT_RD].rev;
  assign rd_spd  = bank_q[SLOT_RD].spd;
  assign rd_tmr  = bank_q[SLOT_RD].tmr;
  assign s0_ph   = bank_q[SLOT_S0].ph;
  assign s0_rev  = bank_q[SLOT_S0].rev;
  assign s0_spd  = bank_q[SLOT_S0].spd;
  assign s0_tmr  = bank_q[SLOT_S0].tmr;
  assign s1_ph   = bank_q[SLOT_S1].ph;
  assign s1_rev  = bank_q[SLOT_S1].rev;
  assign s1_spd  = bank_q[SLOT_S1].spd;
  assign s1_tmr  = bank_q[SLOT_S1].tmr;
  assign hist0   = hist_w[0];
  assign hist1   = hist_w[1];
  assign hist2   = hist_w[2];
  assign hist3   = hist_w[3];
endmodule

// File: rtl/qcap_unit_chk.sv
module qcap_unit_chk #(
  parameter int SPD_W = 28,
  parameter int TMR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             ab_a,
  input logic             ab_b,
  input logic             sw_read,
  input logic [3:0]       evt_flag,
  input logic [3:0]       evt_en,
  input logic [SPD_W-1:0] spd_cnt,
  input logic [TMR_W-1:0] tmr_cnt,
  input logic [31:0]      rd_tmr,
  input logic [31:0]      hist0
);
  localparam logic [SPD_W-1:0] SMAX = {SPD_W{1'b1}};

  logic [1:0] ab_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ab_seen_q <= 2'b11;
    else        ab_seen_q <= {ab_a, ab_b};
  end

  assert_tmr_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tmr_cnt == $past(tmr_cnt) + 1'b1);

  assert_step_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> spd_cnt == '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_cnt == SMAX && !step) |=> spd_cnt == SMAX);

  assert_read_takes_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_read |=> rd_tmr == 32'($past(tmr_cnt)));

  assert_read_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_read && ((evt_flag & evt_en) == 4'b0)) |=> $stable(rd_tmr));

  assert_hist_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ab_seen_q == 2'b00 && {ab_a, ab_b} != 2'b00) |=> $stable(hist0));
endmodule

bind qcap_unit qcap_unit_chk #(.SPD_W(SPD_W), .TMR_W(TMR_W)) i_qcap_unit_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .ab_a(ab_a), .ab_b(ab_b),
  .sw_read(sw_read), .evt_flag(evt_flag), .evt_en(evt_en),
  .spd_cnt(spd_cnt), .tmr_cnt(tmr_cnt), .rd_tmr(rd_tmr), .hist0(hist0)
);

// File: tb/test_qcap_unit.sv
module test_qcap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PH_W  = 21;
  localparam int SPD_W = 8;
  localparam int TMR_W = 32;
  localparam logic [SPD_W-1:0] SMAX = {SPD_W{1'b1}};

  logic clk, rst_n;
  logic step, dir, ab_a, ab_b, sw_read, snap_in, snap_en;
  logic [PH_W-1:0] ph_cnt;
  logic [31:0] rev_cnt;
  logic [3:0] evt_flag, evt_en;
  logic [SPD_W-1:0] spd_cnt;
  logic [TMR_W-1:0] tmr_cnt;
  logic [31:0] rd_ph, rd_rev, rd_spd, rd_tmr, s0_ph, s0_rev, s0_spd, s0_tmr;
  logic [31:0] s1_ph, s1_rev, s1_spd, s1_tmr, hist0, hist1, hist2, hist3;

  qcap_unit #(.PH_W(PH_W), .SPD_W(SPD_W), .TMR_W(TMR_W)) i_qcap_unit (.*);

  int checks = 0, failures = 0, cycles = 0;

  // Bench reference state
  logic [SPD_W-1:0] m_spd;
  logic [31:0] m_tmr;
  logic [31:0] m_bank [3][4];
  logic [31:0] m_hist [4];
  logic [1:0] m_abp;
  logic m_snp, m_sel;

  function automatic logic [31:0] f_ph(logic [PH_W-1:0] p, logic d, logic a, logic b);
    logic [31:0] w = '0;
    w[PH_W-1:0] = p; w[30] = d; w[26] = a; w[25] = b;
    return w;
  endfunction

  function automatic logic [31:0] f_spd(logic [SPD_W-1:0] s, logic d, logic a, logic b);
    logic [31:0] w = '0;
    w[SPD_W-1:0] = s; w[31] = d; w[30] = a; w[29] = b;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_spd = '0; m_tmr = '0; m_abp = 2'b11; m_snp = 1'b0; m_sel = 1'b0;
      for (int i = 0; i < 3; i++) for (int j = 0; j < 4; j++) m_bank[i][j] = '0;
      for (int i = 0; i < 4; i++) m_hist[i] = '0;
    end else begin
      logic [31:0] w [4];
      w[0] = f_ph(ph_cnt, dir, ab_a, ab_b);
      w[1] = rev_cnt;
      w[2] = f_spd(m_spd, dir, ab_a, ab_b);
      w[3] = m_tmr;
      if (sw_read || (evt_flag & evt_en) != 0)
        for (int j = 0; j < 4; j++) m_bank[0][j] = w[j];
      if (snap_en && snap_in && !m_snp) begin
        for (int j = 0; j < 4; j++) m_bank[m_sel ? 2 : 1][j] = w[j];
        m_sel = ~m_sel;
      end
      m_snp = snap_in;
      if (m_abp == 2'b00 && {ab_a, ab_b} != 2'b00) begin
        for (int i = 3; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = 32'(m_spd);
      end
      m_abp = {ab_a, ab_b};
      m_spd = step ? '0 : (m_spd == SMAX ? m_spd : m_spd + 1'b1);
      m_tmr = m_tmr + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 timer", tmr_cnt, m_tmr);
    chk("R3 speed", 32'(spd_cnt), 32'(m_spd));
    chk("R4 rd_ph R7", rd_ph, m_bank[0][0]);
    chk("R4 rd_rev", rd_rev, m_bank[0][1]);
    chk("R4 rd_spd R8", rd_spd, m_bank[0][2]);
    chk("R4 rd_tmr", rd_tmr, m_bank[0][3]);
    chk("R6 s0_ph", s0_ph, m_bank[1][0]);
    chk("R6 s0_rev", s0_rev, m_bank[1][1]);
    chk("R6 s0_spd", s0_spd, m_bank[1][2]);
    chk("R6 s0_tmr", s0_tmr, m_bank[1][3]);
    chk("R6 s1_ph", s1_ph, m_bank[2][0]);
    chk("R6 s1_rev", s1_rev, m_bank[2][1]);
    chk("R6 s1_spd", s1_spd, m_bank[2][2]);
    chk("R6 s1_tmr", s1_tmr, m_bank[2][3]);
    chk("R9 hist0", hist0, m_hist[0]);
    chk("R9 hist1", hist1, m_hist[1]);
    chk("R9 hist2", hist2, m_hist[2]);
    chk("R9 hist3", hist3, m_hist[3]);
  endtask

  // one cycle: inputs already set at negedge, advance to next negedge, compare
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    sw_read = 0; step = 0; evt_flag = '0;
  endtask

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      summary();
    end
  end

  initial begin
    logic [31:0] snap_tmr;
    void'($urandom(32'd2024));
    rst_n = 0; step = 0; dir = 0; ab_a = 0; ab_b = 0; sw_read = 0;
    snap_in = 0; snap_en = 0; ph_cnt = '0; rev_cnt = '0; evt_flag = '0; evt_en = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 spd", 32'(spd_cnt), 0); chk("R1 tmr", tmr_cnt, 0);
    chk("R1 rd_tmr", rd_tmr, 0); chk("R1 s0_ph", s0_ph, 0);
    chk("R1 s1_spd", s1_spd, 0); chk("R1 hist3", hist3, 0);
    ab_a = 1; ab_b = 1;
    rst_n = 1;
    // first cycle after reset with AB=11: no history shift (R9)
    tick();
    chk("R9 no shift after reset", hist0, 0);

    // R7/R8 directed field layout via software read
    ph_cnt = 21'h12345; dir = 1; ab_a = 1; ab_b = 0; rev_cnt = 32'hCAFE0001;
    sw_read = 1;
    tick();
    chk("R7 phase word", rd_ph, 32'h4401_2345);
    chk("R8 speed flags", rd_spd & 32'hE000_0000, 32'hC000_0000);
    chk("R8 rev word", rd_rev, 32'hCAFE0001);

    // R5: flag without enable ignored, then with enable loads
    snap_tmr = rd_tmr;
    evt_en = 4'b0101; evt_flag = 4'b1010;
    tick();
    chk("R5 masked flag ignored", rd_tmr, snap_tmr);
    evt_flag = 4'b0100;
    tick();
    chk("R5 enabled flag loads", rd_tmr, m_tmr - 1);

    // R6: disabled edge ignored, then alternation
    snap_en = 0; snap_in = 1; tick(); snap_in = 0; tick();
    chk("R6 disabled edge s0", s0_tmr, 0);
    snap_en = 1; snap_in = 1; tick();
    chk("R6 first edge bank0", s0_tmr, m_tmr - 1);
    tick(); snap_in = 0; tick(); snap_in = 1; tick();
    chk("R6 second edge bank1", s1_tmr, m_tmr - 1);
    snap_in = 0;

    // R9: exit from 00 shifts history
    ab_a = 0; ab_b = 0; tick();
    ab_a = 0; ab_b = 1; tick();
    chk("R9 shift on exit from 00", hist0, 32'(m_hist[0]));

    // R3: saturation with no steps
    repeat (300) tick();
    chk("R3 saturated", 32'(spd_cnt), 32'(SMAX));
    step = 1; tick();
    chk("R3 restart after step", 32'(spd_cnt), 0);

    // constrained random run
    for (int n = 0; n < 4000; n++) begin
      step = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) {ab_a, ab_b} = 2'($urandom_range(0, 3));
      dir = 1'($urandom_range(0, 1));
      ph_cnt = PH_W'($urandom());
      rev_cnt = $urandom();
      sw_read = ($urandom_range(0, 15) == 0);
      evt_flag = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(1, 15)) : 4'b0;
      if (n % 64 == 0) evt_en = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0) snap_in = ~snap_in;
      if (n % 50 == 0) snap_en = ($urandom_range(0, 3) != 0);
      tick();
    end
    summary();
  end
endmodule